// File: doc/BRIEF.md
# Region-Based Secure Memory Filter

This block sits in the path from a bus master to a DRAM controller and decides, for every single-beat request, whether it may proceed. Each request carries a world tag (secure or normal). The address is looked up in a small table of programmable regions. Each region has a power-of-two size, is aligned to that size, and has a world permission. Allowed requests are handed downstream unchanged, and the downstream answer is returned to the master. Denied requests never reach the controller. The filter answers them itself with an error response, raises a one-cycle abort toward the processor, and records the offending address.

The region table and the fault address register sit behind a separate configuration port. This port accepts only secure-tagged accesses. Only one transaction is in flight at a time: a new request is not taken until the previous response has been returned.

Top module: `secmem_filter`

## Requirements
- R1: An allowed request appears on the downstream port in the same cycle with identical address, write flag, write data and world tag. The downstream response is returned to the master unchanged.
- R2: A region with permission code 00 (secure-only) accepts secure-tagged requests and denies normal-tagged ones.
- R3: A region with permission code 01 (shared) accepts requests of both worlds.
- R4: A region with permission code 10 (normal-only, inverted) accepts normal-tagged requests and denies secure-tagged ones.
- R5: When enabled regions overlap, the region with the higher index decides.
- R6: An address that hits no enabled region is allowed only for secure requests. After reset all regions are disabled.
- R7: A denied request is never forwarded. In the cycle after acceptance the filter returns a response with the error flag set and read data zero.
- R8: A denial raises `abort` for exactly one cycle, in the same cycle as its error response.
- R9: The address of the last denied request is held in the fault register at configuration word 2*N_REGIONS. A secure read returns it.
- R10: Configuration writes tagged normal are ignored and answered with `cfg_err`=1. The word layout is: word 2i is the base of region i; word 2i+1 is its control, with bit 0 enable, bits 2:1 the permission code and bits 13:8 the log2 of the size.
- R11: Any normal-tagged configuration read returns zero data with `cfg_err`=1. Configuration responses appear one cycle after the request.
- R12: After a request is accepted, `req_ready` stays low until its response has been delivered.
- R13: A region with size exponent k covers exactly the addresses that equal its base in all bits from k upward. The first address past the region's end misses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_secure | input | 1 | World tag, 1 = secure |
| rsp_valid | output | 1 | Response to master valid |
| rsp_rdata | output | DW | Read data to master |
| rsp_err | output | 1 | Error response |
| abort | output | 1 | External-abort pulse on denial |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream ready |
| dn_addr | output | AW | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | DW | Downstream write data |
| dn_secure | output | 1 | Downstream world tag |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | DW | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error |
| cfg_valid | input | 1 | Configuration access valid |
| cfg_write | input | 1 | Configuration write |
| cfg_secure | input | 1 | Configuration access world tag |
| cfg_idx | input | IW | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_ack | output | 1 | Configuration response valid |
| cfg_rdata | output | 32 | Configuration read data |
| cfg_err | output | 1 | Configuration access refused |

## Verification
Four overlapping regions are programmed, one for each permission code plus an overlapping shared window inside the secure region. A table of accesses then probes each region with both world tags. The addresses sit at the inner and outer edges of regions, so permission decoding, overlap priority, size masking and the default fallback each produce a different allow/deny pattern. Directed accesses before programming cover the reset default. Configuration accesses with each world tag separate the ignored normal writes and the zero normal reads from secure readback of the table and of the captured fault address.

// File: rtl/secflt_pkg.sv
package secflt_pkg;

    typedef enum logic [1:0] {
        PERM_SEC     = 2'b00,
        PERM_SHARED  = 2'b01,
        PERM_NS_ONLY = 2'b10,
        PERM_LOCKED  = 2'b11
    } perm_e;

    typedef struct packed {
        logic       en;
        perm_e      perm;
        logic [5:0] lg;
    } rattr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_FWD  = 2'b01,
        ST_DENY = 2'b10
    } fst_e;

    localparam int CFG_DW = 32;

    function automatic logic perm_ok(perm_e p, logic sec);
        case (p)
            PERM_SEC:     return sec;
            PERM_SHARED:  return 1'b1;
            PERM_NS_ONLY: return !sec;
            default:      return 1'b0;
        endcase
    endfunction

    function automatic logic [CFG_DW-1:0] ctrl_pack(rattr_t a);
        return {18'b0, a.lg, 5'b0, a.perm, a.en};
    endfunction

    function automatic rattr_t ctrl_unpack(logic [CFG_DW-1:0] w);
        rattr_t a;
        a.en   = w[0];
        a.perm = perm_e'(w[2:1]);
        a.lg   = w[13:8];
        return a;
    endfunction

endpackage

// File: rtl/secflt_regs.sv
module secflt_regs
    import secflt_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 4,
    parameter int IW   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic              cfg_secure,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              cfg_err,
    input  logic              fault_we,
    input  logic [AW-1:0]     fault_addr_in,
    output logic [AW-1:0]     base_o [NREG],
    output rattr_t            attr_o [NREG],
    output logic [AW-1:0]     fault_q
);
    localparam int FAULT_IDX = 2 * NREG;

    logic              in_rng, is_fault, ok_acc;
    logic [CFG_DW-1:0] rd_word;

    always_comb begin
        in_rng   = int'(cfg_idx) < FAULT_IDX;
        is_fault = int'(cfg_idx) == FAULT_IDX;
        ok_acc   = cfg_secure && (cfg_write ? in_rng : (in_rng || is_fault));
        rd_word  = '0;
        for (int i = 0; i < NREG; i++) begin
            if (int'(cfg_idx) == 2 * i)     rd_word[AW-1:0] = base_o[i];
            if (int'(cfg_idx) == 2 * i + 1) rd_word = ctrl_pack(attr_o[i]);
        end
        if (is_fault) rd_word[AW-1:0] = fault_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_ack   <= 1'b0;
            cfg_err   <= 1'b0;
            cfg_rdata <= '0;
            fault_q   <= '0;
            for (int i = 0; i < NREG; i++) begin
                base_o[i] <= '0;
                attr_o[i] <= '0;
            end
        end else begin
            cfg_ack   <= cfg_valid;
            cfg_err   <= cfg_valid && !ok_acc;
            cfg_rdata <= (cfg_valid && !cfg_write && ok_acc) ? rd_word : '0;
            if (cfg_valid && cfg_write && ok_acc) begin
                for (int i = 0; i < NREG; i++) begin
                    if (int'(cfg_idx) == 2 * i)     base_o[i] <= cfg_wdata[AW-1:0];
                    if (int'(cfg_idx) == 2 * i + 1) attr_o[i] <= ctrl_unpack(cfg_wdata);
                end
            end
            if (fault_we) fault_q <= fault_addr_in;
        end
    end

endmodule

// File: rtl/secflt_lookup.sv
module secflt_lookup
    import secflt_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 4
) (
    input  logic [AW-1:0] addr,
    input  logic          secure,
    input  logic [AW-1:0] base [NREG],
    input  rattr_t        attr [NREG],
    output logic          allow
);
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        logic [AW-1:0] mask;
        assign mask     = {AW{1'b1}} << attr[g].lg;
        assign hit[g]   = attr[g].en && (((addr ^ base[g]) & mask) == '0);
    end

    always_comb begin
        allow = secure;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) allow = perm_ok(attr[i].perm, secure);
        end
    end

endmodule

// File: rtl/secflt_ctrl.sv
module secflt_ctrl
    import secflt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          allow,
    output logic          dn_valid,
    input  logic          dn_ready,
    input  logic          dn_rsp_valid,
    input  logic [DW-1:0] dn_rsp_rdata,
    input  logic          dn_rsp_err,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err,
    output logic          abort,
    output logic          fault_we
);
    fst_e st, st_nx;
    logic idle;

    assign idle      = (st == ST_IDLE);
    assign dn_valid  = req_valid && idle && allow;
    assign fault_we  = req_valid && idle && !allow;
    assign req_ready = idle && (!allow || dn_ready);
    assign abort     = (st == ST_DENY);

    always_comb begin
        st_nx     = st;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        rsp_err   = 1'b0;
        case (st)
            ST_IDLE: begin
                if (fault_we)                   st_nx = ST_DENY;
                else if (dn_valid && dn_ready)  st_nx = ST_FWD;
            end
            ST_FWD: begin
                rsp_valid = dn_rsp_valid;
                rsp_rdata = dn_rsp_rdata;
                rsp_err   = dn_rsp_err;
                if (dn_rsp_valid) st_nx = ST_IDLE;
            end
            ST_DENY: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
                st_nx     = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

endmodule

// File: rtl/secmem_filter.sv
module secmem_filter
    import secflt_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int NREG   = 4,
    parameter int IW     = $clog2(2 * NREG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_secure,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_err,
    output logic              abort,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [AW-1:0]     dn_addr,
    output logic              dn_write,
    output logic [DW-1:0]     dn_wdata,
    output logic              dn_secure,
    input  logic              dn_rsp_valid,
    input  logic [DW-1:0]     dn_rsp_rdata,
    input  logic              dn_rsp_err,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic              cfg_secure,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              cfg_err
);
    logic [AW-1:0] base_q [NREG];
    rattr_t        attr_q [NREG];
    logic [AW-1:0] fault_addr_q;
    logic          allow, fault_we;

    assign dn_addr   = req_addr;
    assign dn_write  = req_write;
    assign dn_wdata  = req_wdata;
    assign dn_secure = req_secure;

    secflt_regs #(.AW(AW), .NREG(NREG), .IW(IW)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_secure(cfg_secure),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .fault_we(fault_we), .fault_addr_in(req_addr),
        .base_o(base_q), .attr_o(attr_q), .fault_q(fault_addr_q)
    );

    secflt_lookup #(.AW(AW), .NREG(NREG)) u_lookup (
        .addr(req_addr), .secure(req_secure),
        .base(base_q), .attr(attr_q), .allow(allow)
    );

    secflt_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .allow(allow),
        .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .abort(abort), .fault_we(fault_we)
    );

endmodule

// File: rtl/secflt_check.sv
module secflt_check #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          dn_valid,
    input logic          dn_ready,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic [DW-1:0] rsp_rdata,
    input logic          abort,
    input logic          cfg_valid,
    input logic          cfg_write,
    input logic          cfg_secure,
    input logic          cfg_ack,
    input logic          cfg_err,
    input logic [AW-1:0] fault_addr_q
);
    a_r7_deny_answer: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !dn_valid) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

    a_r8_abort_pulse: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort);

    a_r8_abort_with_err: assert property (@(posedge clk) disable iff (rst)
        abort |-> (rsp_valid && rsp_err));

    a_r9_fault_capture: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !dn_valid) |=> (fault_addr_q == $past(req_addr)));

    a_r10_cfg_normal_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_write && !cfg_secure) |=> (cfg_ack && cfg_err));

    a_r12_single_flight: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_ready) |=> !req_ready);

endmodule

bind secmem_filter secflt_check #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .dn_valid(dn_valid), .dn_ready(dn_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .abort(abort),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_secure(cfg_secure),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err),
    .fault_addr_q(fault_addr_q)
);

// File: tb/secmem_filter_test.sv
`timescale 1ns/1ps
module secmem_filter_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NREG = 4;
    localparam int IW = $clog2(2 * NREG + 1);
    localparam logic [31:0] MAGIC = 32'hA5A5_0000;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_secure = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err, abort;
    logic [DW-1:0] rsp_rdata;
    logic dn_valid, dn_write, dn_secure;
    logic dn_ready = 1;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata;
    logic dn_rsp_valid = 0, dn_rsp_err = 0;
    logic [DW-1:0] dn_rsp_rdata = '0;
    logic cfg_valid = 0, cfg_write = 0, cfg_secure = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic cfg_ack, cfg_err;
    logic [31:0] cfg_rdata;

    int errors = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    secmem_filter #(.AW(AW), .DW(DW), .NREG(NREG)) uut (.*);

    // downstream memory model: one-cycle response
    always @(posedge clk) begin
        dn_rsp_valid <= dn_valid && dn_ready;
        dn_rsp_err   <= 1'b0;
        dn_rsp_rdata <= dn_write ? '0 : (dn_addr ^ MAGIC);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit sec, input bit wr, input logic [31:0] a, input bit exp_ok, input string tag);
        bit fwd;
        @(negedge clk);
        req_valid = 1; req_secure = sec; req_write = wr; req_addr = a; req_wdata = ~a;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        fwd = dn_valid;
        chk(fwd == exp_ok, {tag, " forward decision"}, 32'(fwd), 32'(exp_ok));
        if (fwd) begin
            chk(dn_addr == a && dn_write == wr && dn_wdata == ~a && dn_secure == sec,
                "R1 pass-through fields", dn_addr, a);
        end
        @(posedge clk); #1;
        req_valid = 0;
        chk(rsp_valid == 1'b1, {tag, " response in next cycle"}, 32'(rsp_valid), 32'd1);
        chk(req_ready == 1'b0, "R12 no second request in flight", 32'(req_ready), 32'd0);
        if (!exp_ok) begin
            chk(rsp_err && rsp_rdata == '0, "R7 error response zero data", rsp_rdata, 32'd0);
            chk(abort == 1'b1, "R8 abort raised", 32'(abort), 32'd1);
        end else begin
            chk(!rsp_err && !abort, "R1 clean response", 32'(rsp_err), 32'd0);
            if (!wr) chk(rsp_rdata == (a ^ MAGIC), "R1 read data returned", rsp_rdata, a ^ MAGIC);
        end
        @(posedge clk); #1;
        chk(abort == 1'b0 && rsp_valid == 1'b0, "R8 abort lasts one cycle", 32'(abort), 32'd0);
    endtask

    task automatic cfg(input bit sec, input bit wr, input int idx, input logic [31:0] wd,
                       output logic [31:0] rd, output logic err);
        @(negedge clk);
        cfg_valid = 1; cfg_secure = sec; cfg_write = wr; cfg_idx = IW'(idx); cfg_wdata = wd;
        @(posedge clk); #1;
        cfg_valid = 0;
        rd = cfg_rdata; err = cfg_err;
        chk(cfg_ack == 1'b1, "R11 config response after one cycle", 32'(cfg_ack), 32'd1);
    endtask

    // {secure, expected allow, address}
    localparam logic [33:0] VEC [12] = '{
        {1'b1, 1'b1, 32'h0000_0100},  // R2
        {1'b0, 1'b0, 32'h0000_0100},  // R2
        {1'b0, 1'b1, 32'h0001_0FFC},  // R3
        {1'b1, 1'b1, 32'h0001_0004},  // R3
        {1'b0, 1'b1, 32'h0002_0000},  // R4
        {1'b1, 1'b0, 32'h0002_0FFF},  // R4
        {1'b0, 1'b1, 32'h0000_8010},  // R5
        {1'b0, 1'b0, 32'h0000_9000},  // R5
        {1'b0, 1'b0, 32'h0001_1000},  // R6
        {1'b1, 1'b1, 32'h0001_1000},  // R6
        {1'b1, 1'b1, 32'h0000_FFFF},  // R13
        {1'b0, 1'b0, 32'h0002_1000}   // R13
    };
    localparam string VTAG [12] = '{"R2", "R2", "R3", "R3", "R4", "R4",
                                    "R5", "R5", "R6", "R6", "R13", "R13"};

    initial begin
        logic [31:0] rd;
        logic err;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(req_ready && !abort && !rsp_valid && !cfg_ack, "R6 reset state", 32'(req_ready), 32'd1);

        // reset default: secure only
        access(1'b0, 1'b0, 32'h0000_0100, 1'b0, "R6 default normal");
        access(1'b1, 1'b0, 32'h0000_0100, 1'b1, "R6 default secure");

        // program regions
        cfg(1, 1, 0, 32'h0000_0000, rd, err); cfg(1, 1, 1, 32'h0000_1001, rd, err);
        cfg(1, 1, 2, 32'h0001_0000, rd, err); cfg(1, 1, 3, 32'h0000_0C03, rd, err);
        cfg(1, 1, 4, 32'h0002_0000, rd, err); cfg(1, 1, 5, 32'h0000_0C05, rd, err);
        cfg(1, 1, 6, 32'h0000_8000, rd, err); cfg(1, 1, 7, 32'h0000_0C03, rd, err);
        chk(err == 1'b0, "R10 secure write accepted", 32'(err), 32'd0);
        cfg(1, 0, 4, 32'h0, rd, err);
        chk(rd == 32'h0002_0000 && !err, "R10 base readback", rd, 32'h0002_0000);

        for (int i = 0; i < 12; i++) begin
            access(VEC[i][33], 1'(i % 2), VEC[i][31:0], VEC[i][32], VTAG[i]);
        end

        // R9 fault register holds last denied address (last vector)
        cfg(1, 0, 2 * NREG, 32'h0, rd, err);
        chk(rd == 32'h0002_1000 && !err, "R9 fault address", rd, 32'h0002_1000);
        // R11 normal read refused
        cfg(0, 0, 2 * NREG, 32'h0, rd, err);
        chk(rd == 32'h0 && err, "R11 normal fault read zero", rd, 32'h0);
        cfg(0, 0, 3, 32'h0, rd, err);
        chk(rd == 32'h0 && err, "R11 normal table read zero", rd, 32'h0);
        // R10 normal write ignored
        cfg(0, 1, 1, 32'h0000_0000, rd, err);
        chk(err == 1'b1, "R10 normal write flagged", 32'(err), 32'd1);
        cfg(1, 0, 1, 32'h0, rd, err);
        chk(rd == 32'h0000_1001, "R10 control unchanged", rd, 32'h0000_1001);
        access(1'b0, 1'b1, 32'h0000_0200, 1'b0, "R10 region still secure");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule